// File: doc/BRIEF.md
# Packet-Gated Synchronous FIFO

This block is a single-clock first-in first-out buffer. It has a ready/valid handshake on both the write side and the read side, and every word carries a data field and an end-of-packet flag. It reports how many words it holds, and it raises a near-full flag and a near-empty flag at thresholds set by parameters. The storage is an inferred RAM with a registered read port. The read address is computed one word ahead, so a popped word is followed by the next one on the very next cycle.

When packet gating is enabled, the reader sees only packets that are complete. A word becomes visible once a word carrying the end flag has closed its packet. A discard pulse removes every word written since the last closed packet. It does this by moving the write pointer back to a committed pointer.

A small write-side state machine tracks the packet boundary. It has three states:
- `WS_IDLE`: no packet is open.
- `WS_OPEN`: words have been accepted but no end flag yet.
- `WS_CLOSING`: an end flag was accepted on the previous edge, and the committed pointer catches up on this edge.

The transitions between them are:
- **start**: IDLE or CLOSING goes to OPEN on a plain word.
- **close**: any state goes to CLOSING on an end word.
- **settle**: CLOSING goes to IDLE when nothing is written.
- **discard**: any state goes to IDLE on a discard pulse.
- **hold**: the state is otherwise unchanged.

When end-flag support is off, gating and discard are inactive. The block then behaves as a plain FIFO.

Top module: `pkt_fifo`

## Requirements
- R1: During and after a synchronous reset, with no traffic, `out_valid`=0, `in_ready`=1, `near_full`=0, `near_empty`=1 and `fill`=0.
- R2: Words leave in the order they were written, with data and end flag intact. `fill` changes at the edge that accepts a word and counts every accepted word, including words of an open packet. A read and a write in the same cycle leave `fill` unchanged.
- R3: `in_ready` is 0 while `fill` equals DEPTH. A write offered in that state is not taken, and `fill` stays at DEPTH.
- R4: With gating on, `out_valid` stays 0 while the only stored words belong to an open packet. It rises after the second clock edge following the edge that accepts the end word, which is one edge later than in ungated mode.
- R5: The FIFO can be filled to DEPTH with one-word packets. `out_valid` then stays 1 across every read until the last stored packet is consumed, and then falls to 0.
- R6: A one-cycle `discard` pulse removes all words written since the last closed packet. After that edge, `fill` equals the number of words in closed packets. This holds when the write pointer has wrapped past the end of the RAM.
- R7: If `discard` is high in the same cycle as an accepted end word, that packet is dropped. `fill` shows the earlier words of the packet during that cycle, reads 0 after the edge, and `out_valid` never rises.
- R8: `near_full` is 1 exactly when `fill` >= AF_LVL, so it clears once a read takes `fill` below the threshold.
- R9: `near_empty` is 1 when `fill` <= AE_LVL or when no word is readable. With AE_LVL=0 and ungated mode, it falls one edge after the first write, together with `out_valid`.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold their values.
- R11: With LAST_EN=0, `out_last` is 0, gating is off whatever PKT_MODE says (`out_valid` rises one edge after the accepting edge), and `discard` has no effect on `fill`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Write word offered |
| in_ready | output | 1 | FIFO can take a word |
| in_data | input | DATA_W | Write data |
| in_last | input | 1 | Word ends a packet |
| discard | input | 1 | Drop the packet being written |
| out_valid | output | 1 | Read word available |
| out_ready | input | 1 | Reader takes the word |
| out_data | output | DATA_W | Read data |
| out_last | output | 1 | Read word ends a packet |
| fill | output | $clog2(DEPTH)+1 | Number of stored words |
| near_full | output | 1 | fill >= AF_LVL |
| near_empty | output | 1 | fill <= AE_LVL or nothing readable |

## Verification
The outputs become due at three different edges after a write:
- `fill`, `in_ready` and `near_full` change at the accepting edge itself.
- In ungated mode, `out_valid` and `out_data` follow one edge later, because the word must first pass through the RAM.
- In gated mode, `out_valid` follows two edges after the edge that accepts the end word.

The bench drives inputs and samples outputs on the falling edge. It checks the gated instance as still low at the first and second falling edges after the accepting edge, and as high at the third. The plain instance shares the write inputs and is checked against its one-edge latency at the same falling edges.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
    typedef enum logic [1:0] {
        WS_IDLE    = 2'd0,
        WS_OPEN    = 2'd1,
        WS_CLOSING = 2'd2
    } wstate_e;
endpackage

// File: rtl/pkt_fifo_mem.sv
module pkt_fifo_mem #(
    parameter int WORD_W = 9,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end
endmodule

// File: rtl/pkt_fifo_wctl.sv
module pkt_fifo_wctl
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter bit PKT_ON = 1'b1,
    localparam int PW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          push_last,
    input  logic          drop,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] commit_ptr
);
    generate
        if (PKT_ON) begin : g_pkt
            wstate_e       st_q, st_d;
            logic [PW-1:0] wr_q, wr_d, cm_q, cm_d;

            // state register
            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q <= WS_IDLE;
                    wr_q <= '0;
                    cm_q <= '0;
                end else begin
                    st_q <= st_d;
                    wr_q <= wr_d;
                    cm_q <= cm_d;
                end
            end

            // next state and pointer outputs
            always_comb begin
                st_d = st_q;
                wr_d = wr_q + PW'(push);
                cm_d = (st_q == WS_CLOSING) ? wr_q : cm_q;
                if (drop) begin
                    wr_d = (st_q == WS_CLOSING) ? wr_q : cm_q;
                    cm_d = wr_d;
                    st_d = WS_IDLE;
                end else begin
                    unique case (st_q)
                        WS_IDLE: begin
                            if (push && push_last) st_d = WS_CLOSING;
                            else if (push)         st_d = WS_OPEN;
                        end
                        WS_OPEN: begin
                            if (push && push_last) st_d = WS_CLOSING;
                        end
                        WS_CLOSING: begin
                            if (push && push_last) st_d = WS_CLOSING;
                            else if (push)         st_d = WS_OPEN;
                            else                   st_d = WS_IDLE;
                        end
                        default: st_d = WS_IDLE;
                    endcase
                end
            end

            assign wr_ptr     = wr_q;
            assign commit_ptr = cm_q;

            // R6
            commit_lead_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_q - cm_q) <= PW'(DEPTH));

            // R6
            idle_sync_chk: assert property (@(posedge clk) disable iff (rst)
                (st_q == WS_IDLE) |-> (cm_q == wr_q));
        end else begin : g_plain
            logic [PW-1:0] wr_q;
            logic          unused_pkt_inputs;

            always_ff @(posedge clk) begin
                if (rst) wr_q <= '0;
                else     wr_q <= wr_q + PW'(push);
            end

            assign unused_pkt_inputs = push_last ^ drop;
            assign wr_ptr            = wr_q;
            assign commit_ptr        = wr_q;
        end
    endgenerate
endmodule

// File: rtl/pkt_fifo_rctl.sv
module pkt_fifo_rctl #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] vis_src,
    input  logic          pop,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] vis_ptr,
    output logic [AW-1:0] raddr
);
    logic [PW-1:0] rd_q, vis_q, rd_next;

    assign rd_next = rd_q + PW'(pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            vis_q <= '0;
        end else begin
            rd_q  <= rd_next;
            vis_q <= vis_src;
        end
    end

    assign rd_ptr  = rd_q;
    assign vis_ptr = vis_q;
    assign raddr   = rd_next[AW-1:0];
endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 16,
    parameter int AF_LVL   = 12,
    parameter int AE_LVL   = 2,
    parameter bit LAST_EN  = 1'b1,
    parameter bit PKT_MODE = 1'b1,
    parameter bit DROP_EN  = 1'b1,
    localparam int AW      = $clog2(DEPTH),
    localparam int PW      = AW + 1,
    localparam bit PKT_ON  = LAST_EN && PKT_MODE,
    localparam bit DROP_ON = PKT_ON && DROP_EN,
    localparam int WORD_W  = LAST_EN ? DATA_W + 1 : DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              discard,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic [PW-1:0]     fill,
    output logic              near_full,
    output logic              near_empty
);
    logic              push, pop, drop_eff;
    logic [PW-1:0]     wr_ptr, commit_ptr, rd_ptr, vis_ptr, vis_src;
    logic [AW-1:0]     raddr;
    logic [WORD_W-1:0] wword, rword;

    assign fill      = wr_ptr - rd_ptr;
    assign in_ready  = (fill != PW'(DEPTH));
    assign push      = in_valid && in_ready;
    assign out_valid = (vis_ptr != rd_ptr);
    assign pop       = out_valid && out_ready;
    assign drop_eff  = discard && DROP_ON;
    assign vis_src   = PKT_ON ? commit_ptr : wr_ptr;

    assign near_full  = (fill >= PW'(AF_LVL));
    assign near_empty = (fill <= PW'(AE_LVL)) || !out_valid;

    generate
        if (LAST_EN) begin : g_last
            assign wword    = {in_last, in_data};
            assign out_last = rword[DATA_W];
        end else begin : g_nolast
            assign wword    = in_data;
            assign out_last = 1'b0;
        end
    endgenerate

    assign out_data = rword[DATA_W-1:0];

    pkt_fifo_wctl #(.DEPTH(DEPTH), .PKT_ON(PKT_ON)) u_wctl (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_last  (in_last),
        .drop       (drop_eff),
        .wr_ptr     (wr_ptr),
        .commit_ptr (commit_ptr)
    );

    pkt_fifo_rctl #(.DEPTH(DEPTH)) u_rctl (
        .clk     (clk),
        .rst     (rst),
        .vis_src (vis_src),
        .pop     (pop),
        .rd_ptr  (rd_ptr),
        .vis_ptr (vis_ptr),
        .raddr   (raddr)
    );

    pkt_fifo_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (push),
        .waddr (wr_ptr[AW-1:0]),
        .wdata (wword),
        .raddr (raddr),
        .rdata (rword)
    );

    // R3
    fill_cap_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= PW'(DEPTH));

    // R2
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        !drop_eff |=> fill == $past(fill) + PW'($past(push)) - PW'($past(pop)));

    // R4
    vis_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (vis_ptr - rd_ptr) <= fill);

    // R10
    hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid);

    // R10
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_data));
endmodule

// File: tb/pkt_fifo_tb.sv
module pkt_fifo_tb;
    localparam int CLK_P = 10;
    localparam int PW    = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_last = 1'b0, discard = 1'b0;
    logic [7:0] in_data = '0;
    logic rdy_a = 1'b0, rdy_b = 1'b0;

    logic in_ready_a, valid_a, last_a, nf_a, ne_a;
    logic [7:0] data_a;
    logic [PW-1:0] fill_a;
    logic in_ready_b, valid_b, last_b, nf_b, ne_b;
    logic [7:0] data_b;
    logic [PW-1:0] fill_b;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    pkt_fifo #(.DATA_W(8), .DEPTH(16), .AF_LVL(12), .AE_LVL(2),
               .LAST_EN(1'b1), .PKT_MODE(1'b1), .DROP_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_a),
        .in_data(in_data), .in_last(in_last), .discard(discard),
        .out_valid(valid_a), .out_ready(rdy_a), .out_data(data_a),
        .out_last(last_a), .fill(fill_a), .near_full(nf_a), .near_empty(ne_a));

    pkt_fifo #(.DATA_W(8), .DEPTH(16), .AF_LVL(12), .AE_LVL(0),
               .LAST_EN(1'b0), .PKT_MODE(1'b1), .DROP_EN(1'b1)) u_dut_plain (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_b),
        .in_data(in_data), .in_last(in_last), .discard(discard),
        .out_valid(valid_b), .out_ready(rdy_b), .out_data(data_b),
        .out_last(last_b), .fill(fill_b), .near_full(nf_b), .near_empty(ne_b));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ceq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; discard = 1'b0;
        rdy_a = 1'b0; rdy_b = 1'b0;
        tick(); tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic push_word(input logic [7:0] d, input logic l);
        in_valid = 1'b1; in_data = d; in_last = l;
        tick();
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic pop_a(input logic [7:0] d, input logic l, input string req);
        ceq({req, " valid"}, valid_a, 1);
        ceq({req, " data"}, data_a, d);
        ceq({req, " last"}, last_a, l);
        rdy_a = 1'b1;
        tick();
        rdy_a = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick();
        ceq("R1 valid in reset", valid_a, 0);
        do_reset();
        for (int k = 0; k < 3; k++) begin
            ceq("R1 valid", valid_a, 0);
            ceq("R1 ready", in_ready_a, 1);
            ceq("R1 near_full", nf_a, 0);
            ceq("R1 near_empty", ne_a, 1);
            ceq("R1 fill", fill_a, 0);
            tick();
        end
    endtask

    task automatic t_latency();
        do_reset();
        push_word(8'h5A, 1'b1);
        ceq("R2 fill at accept edge", fill_a, 1);
        ceq("R4 gated valid edge0", valid_a, 0);
        ceq("R11 plain valid edge0", valid_b, 0);
        ceq("R9 plain near_empty edge0", ne_b, 1);
        tick();
        ceq("R11 plain valid edge1", valid_b, 1);
        ceq("R11 plain data", data_b, 8'h5A);
        ceq("R11 plain last zero", last_b, 0);
        ceq("R9 plain near_empty edge1", ne_b, 0);
        ceq("R4 gated valid edge1", valid_a, 0);
        tick();
        ceq("R4 gated valid edge2", valid_a, 1);
        pop_a(8'h5A, 1'b1, "R2 first packet");
        ceq("R4 empty after pop", valid_a, 0);
        for (int i = 1; i <= 3; i++) push_word(8'(i), 1'b0);
        tick(); tick(); tick();
        ceq("R4 open packet hidden", valid_a, 0);
        ceq("R2 open words counted", fill_a, 3);
        push_word(8'd4, 1'b1);
        ceq("R4 close edge0", valid_a, 0);
        tick();
        ceq("R4 close edge1", valid_a, 0);
        tick();
        ceq("R4 close edge2", valid_a, 1);
        for (int i = 0; i < 4; i++) pop_a(8'(i + 1), i == 3, "R2 order");
        ceq("R2 drained valid", valid_a, 0);
        ceq("R2 drained fill", fill_a, 0);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < 16; i++) begin
            push_word(8'(i), 1'b1);
            ceq("R8 near_full while filling", nf_a, (i + 1 >= 12) ? 1 : 0);
        end
        ceq("R3 ready low when full", in_ready_a, 0);
        ceq("R3 fill full", fill_a, 16);
        push_word(8'hFF, 1'b1);
        ceq("R3 write ignored when full", fill_a, 16);
        tick(); tick();
        for (int i = 0; i < 16; i++) begin
            ceq("R8 near_full while reading", nf_a, (16 - i >= 12) ? 1 : 0);
            ceq("R9 near_empty while reading", ne_a, (16 - i <= 2) ? 1 : 0);
            pop_a(8'(i), 1'b1, "R5 one-word packets");
        end
        ceq("R5 valid low after last packet", valid_a, 0);
        ceq("R5 fill zero", fill_a, 0);
    endtask

    task automatic t_drop_wrap();
        do_reset();
        for (int i = 0; i < 12; i++) push_word(8'(i), i == 11);
        tick(); tick();
        for (int i = 0; i < 8; i++) pop_a(8'(i), 1'b0, "R6 prefill read");
        ceq("R6 fill before open packet", fill_a, 4);
        for (int i = 0; i < 8; i++) push_word(8'h80 + 8'(i), 1'b0);
        ceq("R6 fill with open packet", fill_a, 12);
        discard = 1'b1;
        tick();
        discard = 1'b0;
        ceq("R6 fill after discard", fill_a, 4);
        for (int i = 8; i < 12; i++) pop_a(8'(i), i == 11, "R6 kept packet");
        ceq("R6 valid after kept packet", valid_a, 0);
        ceq("R6 fill empty", fill_a, 0);
        for (int i = 0; i < 3; i++) push_word(8'h40 + 8'(i), i == 2);
        tick(); tick();
        for (int i = 0; i < 3; i++) pop_a(8'h40 + 8'(i), i == 2, "R6 packet after discard");
        ceq("R6 final valid", valid_a, 0);
    endtask

    task automatic t_drop_on_last();
        do_reset();
        push_word(8'h11, 1'b0);
        in_valid = 1'b1; in_data = 8'h22; in_last = 1'b1; discard = 1'b1;
        ceq("R7 fill during drop cycle", fill_a, 1);
        tick();
        in_valid = 1'b0; in_last = 1'b0; discard = 1'b0;
        ceq("R7 fill after drop", fill_a, 0);
        ceq("R11 plain ignores discard", fill_b, 2);
        for (int k = 0; k < 4; k++) begin
            ceq("R7 valid never rises", valid_a, 0);
            tick();
        end
        ceq("R11 plain data kept", data_b, 8'h11);
    endtask

    task automatic t_hold();
        do_reset();
        push_word(8'hA1, 1'b1);
        push_word(8'hA2, 1'b1);
        tick(); tick();
        for (int k = 0; k < 3; k++) begin
            ceq("R10 valid held", valid_a, 1);
            ceq("R10 data held", data_a, 8'hA1);
            tick();
        end
        pop_a(8'hA1, 1'b1, "R10 first");
        pop_a(8'hA2, 1'b1, "R10 second");
    endtask

    task automatic t_same_cycle();
        int exp_d;
        do_reset();
        for (int i = 1; i <= 3; i++) push_word(8'(i), 1'b0);
        tick();
        for (int i = 0; i < 4; i++) begin
            exp_d = (i < 3) ? i + 1 : 10 + (i - 3);
            in_valid = 1'b1; in_data = 8'(10 + i); rdy_b = 1'b1;
            ceq("R2 plain order under traffic", data_b, exp_d);
            tick();
            ceq("R2 fill steady on read+write", fill_b, 3);
        end
        in_valid = 1'b0; rdy_b = 1'b0;
    endtask

    initial begin
        t_reset();
        t_latency();
        t_full();
        t_drop_wrap();
        t_drop_on_last();
        t_hold();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule